// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a small 16-bit processor. It captures a 9-bit instruction word during the fetch phase, splits it into a 3-bit opcode and three 2-bit register selectors, and walks through a fetch, decode and execute phase. The datapath around it does the arithmetic and holds the registers. The sequencer only tells the datapath what to do in each cycle. It drives the ALU operation, two register read selects, a destination write enable with its select, memory read and write strobes, and an address source with a register index.

Register-to-register instructions finish in execute. Every opcode whose top bit is set goes on to a memory phase before the next fetch. Within the memory phase, a sub-step counter issues the accesses one per cycle. Memory is treated as answering in a single cycle, so no handshake is needed.

Top module: `insn_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero (phase encoding 0 = fetch) and the machine restarts in fetch once `rst` falls, whatever it was doing.
- R2: In fetch, `mem_rd_o`=1, `addr_src_o`=1 (program counter) and all other outputs are 0. The instruction is taken from `insn_i` at the edge that ends fetch, with opcode in bits [8:6], Ri in [5:4], Rj in [3:2] and Rk in [1:0].
- R3: The phase order is fetch(0), decode(1), execute(2). After execute, the machine returns to fetch if opcode bit 2 is 0 and goes to the memory phase(3) if it is 1.
- R4: In decode, execute and the memory phase, `rd_a_sel_o`=Ri and `rd_b_sel_o`=Rj. Decode drives nothing else.
- R5: For opcodes 000 to 011, execute drives `alu_op_o` = opcode[1:0] (00 add, 01 subtract, 10 and, 11 or), `reg_we_o`=1 and `reg_wsel_o`=Rk, with no memory strobe.
- R6: For opcodes 100 (add) and 101 (subtract), the memory phase lasts three cycles with `addr_src_o`=2 (register). The cycles are: read at Ri, then read at Rj, then write at Rk. On the write cycle `alu_op_o` is 00 or 01 from opcode bit 0.
- R7: Opcode 110 takes one memory cycle. That cycle reads at address register Ri and writes register Rj (`reg_we_o`=1, `reg_wsel_o`=Rj). Rk has no effect.
- R8: Opcode 111 takes one memory cycle. That cycle writes memory at address register Rj, with Ri on `rd_a_sel_o` as the data source and no register write. Rk has no effect.
- R9: `reg_we_o` is high for exactly one cycle in each instruction that targets a register, only on its last cycle, and never for 100, 101 or 111. `mem_rd_o` and `mem_wr_o` are never high together.
- R10: `insn_i` is ignored outside fetch: changing it in later phases leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 9 | Instruction word, sampled at the end of fetch |
| phase_o | output | 2 | Current phase: 0 fetch, 1 decode, 2 execute, 3 memory |
| alu_op_o | output | 2 | ALU operation: 0 add, 1 subtract, 2 and, 3 or |
| rd_a_sel_o | output | 2 | First register read select |
| rd_b_sel_o | output | 2 | Second register read select |
| reg_we_o | output | 1 | Destination register write enable |
| reg_wsel_o | output | 2 | Destination register select |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_src_o | output | 2 | Address source: 0 none, 1 program counter, 2 register |
| addr_reg_o | output | 2 | Register whose contents form the memory address |

## Verification
The bench uses the default widths: a 3-bit opcode and 2-bit selectors, which give 512 possible words. It runs every one of those words through its whole instruction. It checks every output in every cycle against values it works out from the opcode and fields. This covers each opcode with every register combination, including equal selectors and the don't-care low bits of the move instructions. During the non-fetch cycles the bench drives the complement of the word on `insn_i`. It also raises reset in the middle of a three-access memory instruction.

// File: rtl/insn_ctrl_pkg.sv
package insn_ctrl_pkg;

    localparam int OP_W     = 3;
    localparam int SEL_W    = 2;
    localparam int INSN_W   = OP_W + 3 * SEL_W;
    localparam int PH_W     = 2;
    localparam int ALU_W    = 2;
    localparam int AS_W     = 2;
    localparam int STEP_W   = 2;
    localparam int DUAL_LAST = 2;  // last sub-step of a three-access op

    typedef enum logic [PH_W-1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_EXTRA  = 2'd3
    } phase_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_e;

    typedef enum logic [AS_W-1:0] {
        AS_NONE = 2'd0,
        AS_PC   = 2'd1,
        AS_REG  = 2'd2
    } asrc_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [SEL_W-1:0] ri;
        logic [SEL_W-1:0] rj;
        logic [SEL_W-1:0] rk;
    } insn_t;

    typedef struct packed {
        alu_e             alu;
        logic [SEL_W-1:0] rda;
        logic [SEL_W-1:0] rdb;
        logic             we;
        logic [SEL_W-1:0] wsel;
        logic             mrd;
        logic             mwr;
        asrc_e            asrc;
        logic [SEL_W-1:0] areg;
    } ctl_t;

    // Top opcode bit routes through the memory phase.
    function automatic logic op_is_mem(input logic [OP_W-1:0] op);
        return op[OP_W-1];
    endfunction

    // Memory-to-memory arithmetic: two reads then one write.
    function automatic logic op_is_dual(input logic [OP_W-1:0] op);
        return op[OP_W-1] && !op[OP_W-2];
    endfunction

endpackage

// File: rtl/insn_ctrl_ir.sv
module insn_ctrl_ir
    import insn_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [INSN_W-1:0] insn_i,
    output insn_t             ir_o
);

    insn_t ir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (load) begin
            ir_q <= insn_t'(insn_i);
        end
    end

    assign ir_o = ir_q;

endmodule

// File: rtl/insn_ctrl_seq.sv
module insn_ctrl_seq
    import insn_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    output phase_e            phase_o,
    output logic [STEP_W-1:0] step_o
);

    phase_e            phase_q, phase_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              last_step;

    assign last_step = op_is_dual(op) ? (step_q == STEP_W'(DUAL_LAST)) : 1'b1;

    always_comb begin
        phase_d = phase_q;
        step_d  = '0;
        case (phase_q)
            PH_FETCH:  phase_d = PH_DECODE;
            PH_DECODE: phase_d = PH_EXEC;
            PH_EXEC:   phase_d = op_is_mem(op) ? PH_EXTRA : PH_FETCH;
            PH_EXTRA: begin
                if (last_step) begin
                    phase_d = PH_FETCH;
                end else begin
                    step_d  = step_q + 1'b1;
                end
            end
            default:   phase_d = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            step_q  <= '0;
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
        end
    end

    assign phase_o = phase_q;
    assign step_o  = step_q;

endmodule

// File: rtl/insn_ctrl_out.sv
module insn_ctrl_out
    import insn_ctrl_pkg::*;
(
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    input  insn_t             ir,
    output ctl_t              ctl_o
);

    always_comb begin
        ctl_o = '0;
        case (phase)
            PH_FETCH: begin
                ctl_o.mrd  = 1'b1;
                ctl_o.asrc = AS_PC;
            end
            PH_DECODE: begin
                ctl_o.rda = ir.ri;
                ctl_o.rdb = ir.rj;
            end
            PH_EXEC: begin
                ctl_o.rda = ir.ri;
                ctl_o.rdb = ir.rj;
                if (!op_is_mem(ir.op)) begin
                    ctl_o.alu  = alu_e'(ir.op[ALU_W-1:0]);
                    ctl_o.we   = 1'b1;
                    ctl_o.wsel = ir.rk;
                end
            end
            PH_EXTRA: begin
                ctl_o.rda  = ir.ri;
                ctl_o.rdb  = ir.rj;
                ctl_o.asrc = AS_REG;
                if (op_is_dual(ir.op)) begin
                    case (step)
                        STEP_W'(0): begin
                            ctl_o.mrd  = 1'b1;
                            ctl_o.areg = ir.ri;
                        end
                        STEP_W'(1): begin
                            ctl_o.mrd  = 1'b1;
                            ctl_o.areg = ir.rj;
                        end
                        default: begin
                            ctl_o.mwr  = 1'b1;
                            ctl_o.areg = ir.rk;
                            ctl_o.alu  = ir.op[0] ? ALU_SUB : ALU_ADD;
                        end
                    endcase
                end else if (!ir.op[0]) begin
                    ctl_o.mrd  = 1'b1;
                    ctl_o.areg = ir.ri;
                    ctl_o.we   = 1'b1;
                    ctl_o.wsel = ir.rj;
                end else begin
                    ctl_o.mwr  = 1'b1;
                    ctl_o.areg = ir.rj;
                end
            end
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/insn_ctrl.sv
module insn_ctrl
    import insn_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [INSN_W-1:0] insn_i,
    output logic [PH_W-1:0]   phase_o,
    output logic [ALU_W-1:0]  alu_op_o,
    output logic [SEL_W-1:0]  rd_a_sel_o,
    output logic [SEL_W-1:0]  rd_b_sel_o,
    output logic              reg_we_o,
    output logic [SEL_W-1:0]  reg_wsel_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [AS_W-1:0]   addr_src_o,
    output logic [SEL_W-1:0]  addr_reg_o
);

    phase_e            phase;
    logic [STEP_W-1:0] step;
    insn_t             ir;
    ctl_t              ctl_raw;
    ctl_t              ctl;

    insn_ctrl_ir u_ir (
        .clk    (clk),
        .rst    (rst),
        .load   (phase == PH_FETCH),
        .insn_i (insn_i),
        .ir_o   (ir)
    );

    insn_ctrl_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .op      (ir.op),
        .phase_o (phase),
        .step_o  (step)
    );

    insn_ctrl_out u_out (
        .phase (phase),
        .step  (step),
        .ir    (ir),
        .ctl_o (ctl_raw)
    );

    // Reset silences every control line, including the fetch strobe.
    assign ctl = rst ? ctl_t'('0) : ctl_raw;

    assign phase_o    = rst ? PH_W'(PH_FETCH) : PH_W'(phase);
    assign alu_op_o   = ctl.alu;
    assign rd_a_sel_o = ctl.rda;
    assign rd_b_sel_o = ctl.rdb;
    assign reg_we_o   = ctl.we;
    assign reg_wsel_o = ctl.wsel;
    assign mem_rd_o   = ctl.mrd;
    assign mem_wr_o   = ctl.mwr;
    assign addr_src_o = ctl.asrc;
    assign addr_reg_o = ctl.areg;

endmodule

// File: rtl/insn_ctrl_chk.sv
module insn_ctrl_chk
    import insn_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [PH_W-1:0]   phase_o,
    input logic              reg_we_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [AS_W-1:0]   addr_src_o,
    input logic [INSN_W-1:0] insn_i
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |-> (!reg_we_o && !mem_rd_o && !mem_wr_o && addr_src_o == '0 && phase_o == '0));

    p_fetch_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_W'(PH_FETCH)) |-> (mem_rd_o && !mem_wr_o && addr_src_o == AS_W'(AS_PC)));

    p_fetch_next_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_W'(PH_FETCH)) |=> (phase_o == PH_W'(PH_DECODE)));

    p_decode_next_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_W'(PH_DECODE)) |=> (phase_o == PH_W'(PH_EXEC)));

    p_mem_next_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_W'(PH_DECODE) && $past(insn_i[INSN_W-1]) && $past(phase_o) == PH_W'(PH_FETCH))
        |=> ##1 (phase_o == PH_W'(PH_EXTRA)));

    p_decode_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_W'(PH_DECODE)) |-> (!reg_we_o && !mem_rd_o && !mem_wr_o));

    p_extra_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_W'(PH_EXTRA) && (mem_rd_o || mem_wr_o)) |-> (addr_src_o == AS_W'(AS_REG)));

    p_rdwr_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    p_we_single_r9: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> (!reg_we_o && phase_o == PH_W'(PH_FETCH)));

endmodule

bind insn_ctrl insn_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase_o    (phase_o),
    .reg_we_o   (reg_we_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .addr_src_o (addr_src_o),
    .insn_i     (insn_i)
);

// File: tb/insn_ctrl_tb_top.sv
module insn_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] insn_i = '0;
    logic [1:0] phase_o, alu_op_o, rd_a_sel_o, rd_b_sel_o, reg_wsel_o, addr_src_o, addr_reg_o;
    logic       reg_we_o, mem_rd_o, mem_wr_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    insn_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .insn_i     (insn_i),
        .phase_o    (phase_o),
        .alu_op_o   (alu_op_o),
        .rd_a_sel_o (rd_a_sel_o),
        .rd_b_sel_o (rd_b_sel_o),
        .reg_we_o   (reg_we_o),
        .reg_wsel_o (reg_wsel_o),
        .mem_rd_o   (mem_rd_o),
        .mem_wr_o   (mem_wr_o),
        .addr_src_o (addr_src_o),
        .addr_reg_o (addr_reg_o)
    );

    // {phase, alu, rda, rdb, we, wsel, rd, wr, asrc, areg}
    function automatic logic [17:0] pack_out(
        input logic [1:0] ph, input logic [1:0] alu, input logic [1:0] rda,
        input logic [1:0] rdb, input logic we, input logic [1:0] wsel,
        input logic rd, input logic wr, input logic [1:0] asrc, input logic [1:0] areg);
        return {ph, alu, rda, rdb, we, wsel, rd, wr, asrc, areg};
    endfunction

    function automatic logic [17:0] observed();
        return pack_out(phase_o, alu_op_o, rd_a_sel_o, rd_b_sel_o, reg_we_o,
                        reg_wsel_o, mem_rd_o, mem_wr_o, addr_src_o, addr_reg_o);
    endfunction

    function automatic int insn_len(input logic [8:0] w);
        if (!w[8])          return 3;
        else if (!w[7])     return 6;
        else                return 4;
    endfunction

    function automatic logic [17:0] expect_at(input logic [8:0] w, input int k);
        logic [2:0] op = w[8:6];
        logic [1:0] ri = w[5:4], rj = w[3:2], rk = w[1:0];
        if (k == 0) return pack_out(2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 2'd0);
        if (k == 1) return pack_out(2'd1, 2'd0, ri, rj, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0);
        if (k == 2) begin
            if (!op[2]) return pack_out(2'd2, op[1:0], ri, rj, 1'b1, rk, 1'b0, 1'b0, 2'd0, 2'd0);
            return pack_out(2'd2, 2'd0, ri, rj, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0);
        end
        if (!op[1]) begin
            if (k == 3) return pack_out(2'd3, 2'd0, ri, rj, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, ri);
            if (k == 4) return pack_out(2'd3, 2'd0, ri, rj, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, rj);
            return pack_out(2'd3, {1'b0, op[0]}, ri, rj, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2, rk);
        end
        if (!op[0]) return pack_out(2'd3, 2'd0, ri, rj, 1'b1, rj, 1'b1, 1'b0, 2'd2, ri);
        return pack_out(2'd3, 2'd0, ri, rj, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2, rj);
    endfunction

    function automatic string tag_for(input logic [8:0] w, input int k);
        if (k == 0) return "R2";
        if (k == 1) return "R4 R10";
        if (k == 2) return w[8] ? "R3 R10" : "R5 R10";
        if (!w[7])  return "R6 R10";
        return w[6] ? "R8 R10" : "R7 R10";
    endfunction

    task automatic check_vec(input string tag, input logic [8:0] w, input int k,
                             input logic [17:0] got, input logic [17:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s insn=%h cycle=%0d actual=%h expected=%h", tag, w, k, got, exp);
        end
    endtask

    task automatic run_insn(input logic [8:0] w);
        int we_cnt = 0;
        int len = insn_len(w);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            insn_i = (k == 0) ? w : ~w;  // garbage outside fetch (R10)
            #1;
            check_vec(tag_for(w, k), w, k, observed(), expect_at(w, k));
            if (reg_we_o) we_cnt++;
        end
        // R9: one write pulse for register-destination instructions only
        n_checks++;
        if (we_cnt != ((!w[8] || w[8:6] == 3'b110) ? 1 : 0)) begin
            n_fail++;
            $display("FAIL R9 insn=%h actual=%0d expected=%0d write pulses", w, we_cnt,
                     (!w[8] || w[8:6] == 3'b110) ? 1 : 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: outputs quiet while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        insn_i = 9'h1FF;
        #1;
        check_vec("R1", 9'h000, 0, observed(), 18'h0);
        @(posedge clk);
        #2;
        rst = 1'b0;

        // Exhaustive sweep: every opcode with every selector combination
        for (int w = 0; w < 512; w++) begin
            run_insn(9'(w));
        end

        // R1: reset in the middle of a three-access memory instruction
        begin
            logic [8:0] w = 9'b101_10_01_11;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                insn_i = (k == 0) ? w : ~w;
            end
            @(negedge clk);
            rst = 1'b1;
            #1;
            check_vec("R1", w, 5, observed(), 18'h0);
            @(posedge clk);
            #2;
            rst = 1'b0;
            #1;
            check_vec("R1", w, 6, observed(), expect_at(w, 0));
        end
        // Resumes cleanly after the abort
        run_insn(9'b110_11_00_10);
        run_insn(9'b001_01_10_11);

        finish_run();
    end

endmodule